// File: doc/BRIEF.md
# Clock Divider Setting Rate Calculator

This block turns a 16-bit clock divider setting and a parent clock frequency into the output frequency that setting produces. The setting carries a clock-enable flag, an integer divisor, and an optional fractional stage. The fractional stage scales the divided rate by a ratio N/(N+1) or N/(N-1) and then rounds the result up to the next multiple of 1000 Hz.

Software or a neighbouring controller presents the setting and the parent frequency together with a one-cycle start pulse. A single restoring divider is reused for each division step. Because of that, the latency is fixed for each kind of setting, and a one-cycle done pulse marks the moment the result and the error flag are updated. The result and the flag hold their values until the next done pulse.

Top module: `clk_rate_calc`

## Requirements
- R1: After reset, busy, done, rate_hz and div_err are all 0.
- R2: When cfg bit 15 (clock enable) is 0, a start gives rate_hz = 0 and div_err = 0, with done high in the cycle right after the start edge. All other cfg bits are ignored.
- R3: When cfg bit 15 is 1 and cfg bits 7:0 (integer divisor) are 0, a start gives rate_hz = 0 and div_err = 1, with done in the cycle right after the start edge.
- R4: When cfg bit 14 (fraction enable) is 0 and the divisor D is nonzero, rate_hz = floor(parent_hz / D) with no rounding. done follows the start edge by IW+2 clock edges, which is 42 at the defaults.
- R5: When cfg bit 14 is 1, N is found as follows:
  - cfg bits 13:12 select a table value: 0 gives 0, 1 gives 16, 2 gives 8, 3 gives 4.
  - N is that table value times (1 + cfg bits 10:8).
  - The denominator M is N+1 when cfg bit 11 is 0 and N-1 when it is 1.
  - The result is floor(floor(parent_hz/D)·N/M), rounded up to a multiple of 1000.
  - done follows the start edge by 3·(IW+2) edges, which is 126 at the defaults.
- R6: When the fraction is enabled with table select 0, rate_hz = 0 and div_err = 0, with done after IW+2 edges.
- R7: A result above 2^32-1 saturates to 0xFFFFFFFF.
- R8: busy is high from the edge that accepts a start until the edge that raises done. A start while busy is high is ignored.
- R9: done is high for one cycle per accepted start. rate_hz and div_err change only on the edge that raises done.
- R10: A fractional result that is already a multiple of 1000 is not increased by the rounding step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute |
| cfg | input | 16 | Divider setting word |
| parent_hz | input | 32 | Parent clock frequency in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| rate_hz | output | 32 | Computed output frequency in Hz |
| div_err | output | 1 | Set with done when the divisor field is zero |

## Verification
The bench aims at the settings where a slip in the datapath changes the number that comes out:
- **Clock disabled with every other field set.** A decoder that does not let the enable bit win would report a nonzero rate here.
- **Zero divisor.** A design without the guard would divide by zero and either hang or return all ones.
- **Table select 0 with the fraction enabled, and the fraction-up direction.** A wrong sign on the denominator moves the result by several kilohertz.
- **Exact multiples of 1000.** A round-up that always adds would add 1000 Hz here.
- **Largest parent frequency with an upward ratio.** A missing saturation would wrap the result.
- **Start pulses while busy and in the done cycle.** These catch a design that restarts mid-operation, or one that drops a start arriving as a result completes.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  localparam int CFG_W      = 16;
  localparam int DIVF_LSB   = 0;
  localparam int DIVF_W     = 8;
  localparam int PRE_LSB    = 8;
  localparam int PRE_W      = 3;
  localparam int DIR_BIT    = 11;
  localparam int SEL_LSB    = 12;
  localparam int SEL_W      = 2;
  localparam int FRAC_BIT   = 14;
  localparam int EN_BIT     = 15;
  localparam int NUM_W      = 8;
  localparam int SEL_N      = 1 << SEL_W;

  typedef struct packed {
    logic              clk_en;
    logic              frac_en;
    logic              dir_up;
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [DIVF_W-1:0] divisor;
  } setting_t;

  // Table entry for a select index: 0, then 16 halving per step.
  function automatic int sel_weight(int idx);
    return (idx == 0) ? 0 : (32 >> idx);
  endfunction
endpackage

// File: rtl/rate_cfg_decode.sv
module rate_cfg_decode
  import clk_rate_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output setting_t         fields,
  output logic [NUM_W-1:0] num,
  output logic [NUM_W-1:0] den
);
  logic [NUM_W-1:0] weight [SEL_N];

  for (genvar g = 0; g < SEL_N; g++) begin : g_tbl
    assign weight[g] = NUM_W'(sel_weight(g));
  end

  always_comb begin
    fields.clk_en  = cfg[EN_BIT];
    fields.frac_en = cfg[FRAC_BIT];
    fields.dir_up  = cfg[DIR_BIT];
    fields.sel     = cfg[SEL_LSB +: SEL_W];
    fields.pre     = cfg[PRE_LSB +: PRE_W];
    fields.divisor = cfg[DIVF_LSB +: DIVF_W];
    num = NUM_W'(weight[fields.sel] * (NUM_W'(fields.pre) + NUM_W'(1)));
    den = fields.dir_up ? (num - NUM_W'(1)) : (num + NUM_W'(1));
  end
endmodule

// File: rtl/rate_seq_div.sv
module rate_seq_div #(
  parameter int IW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [IW-1:0] dividend,
  input  logic [IW-1:0] divisor,
  output logic          ready,
  output logic [IW-1:0] quo,
  output logic [IW-1:0] rem
);
  localparam int CW = $clog2(IW + 1);

  logic [IW-1:0] dvsr;
  logic [CW-1:0] cnt;
  logic          run;
  logic [IW:0]   shifted;
  logic [IW:0]   trial;
  logic          fits;

  always_comb begin
    shifted = {rem, quo[IW-1]};
    trial   = shifted - {1'b0, dvsr};
    fits    = shifted >= {1'b0, dvsr};
  end

  always_ff @(posedge clk) begin
    ready <= 1'b0;
    if (rst) begin
      quo  <= '0;
      rem  <= '0;
      dvsr <= '0;
      cnt  <= '0;
      run  <= 1'b0;
    end else if (go) begin
      quo  <= dividend;
      rem  <= '0;
      dvsr <= divisor;
      cnt  <= CW'(IW);
      run  <= 1'b1;
    end else if (run) begin
      rem <= fits ? trial[IW-1:0] : shifted[IW-1:0];
      quo <= {quo[IW-2:0], fits};
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        run   <= 1'b0;
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_rate_calc.sv
module clk_rate_calc
  import clk_rate_pkg::*;
#(
  parameter int RW  = 32,
  parameter int IW  = 40,
  parameter int RND = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg,
  input  logic [RW-1:0]    parent_hz,
  output logic             busy,
  output logic             done,
  output logic [RW-1:0]    rate_hz,
  output logic             div_err
);
  typedef enum logic [1:0] {S_IDLE, S_BASE, S_SCALE, S_ROUND} state_t;

  state_t           state;
  setting_t         fields;
  logic [NUM_W-1:0] num, den, num_q, den_q;
  logic             frac_q;
  logic             go_q;
  logic [IW-1:0]    div_a, div_b, q_hold;
  logic             d_ready;
  logic [IW-1:0]    d_quo, d_rem;
  logic [IW:0]      rounded;
  logic             too_big;

  rate_cfg_decode u_dec (
    .cfg    (cfg),
    .fields (fields),
    .num    (num),
    .den    (den)
  );

  rate_seq_div #(.IW(IW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (go_q),
    .dividend (div_a),
    .divisor  (div_b),
    .ready    (d_ready),
    .quo      (d_quo),
    .rem      (d_rem)
  );

  always_comb begin
    rounded = {1'b0, q_hold} +
              ((d_rem == '0) ? '0 : ((IW+1)'(RND) - {1'b0, d_rem}));
    too_big = |rounded[IW:RW];
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    go_q <= 1'b0;
    done <= 1'b0;
    if (rst) begin
      state   <= S_IDLE;
      div_a   <= '0;
      div_b   <= '0;
      q_hold  <= '0;
      num_q   <= '0;
      den_q   <= '0;
      frac_q  <= 1'b0;
      rate_hz <= '0;
      div_err <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          if (!fields.clk_en || fields.divisor == '0) begin
            rate_hz <= '0;
            div_err <= fields.clk_en;
            done    <= 1'b1;
          end else begin
            num_q  <= num;
            den_q  <= den;
            frac_q <= fields.frac_en;
            div_a  <= IW'(parent_hz);
            div_b  <= IW'(fields.divisor);
            go_q   <= 1'b1;
            state  <= S_BASE;
          end
        end
        S_BASE: if (d_ready) begin
          if (!frac_q || num_q == '0) begin
            rate_hz <= frac_q ? '0 : d_quo[RW-1:0];
            div_err <= 1'b0;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            div_a <= d_quo * IW'(num_q);
            div_b <= IW'(den_q);
            go_q  <= 1'b1;
            state <= S_SCALE;
          end
        end
        S_SCALE: if (d_ready) begin
          q_hold <= d_quo;
          div_a  <= d_quo;
          div_b  <= IW'(RND);
          go_q   <= 1'b1;
          state  <= S_ROUND;
        end
        S_ROUND: if (d_ready) begin
          rate_hz <= too_big ? {RW{1'b1}} : rounded[RW-1:0];
          div_err <= 1'b0;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_rate_calc_chk.sv
module clk_rate_calc_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [15:0]   cfg,
  input logic [RW-1:0] parent_hz,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] rate_hz,
  input logic          div_err
);
  p_disabled_fast_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !cfg[15]) |=> (done && rate_hz == '0 && !div_err));

  p_zero_div_err_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && cfg[15] && cfg[7:0] == 8'd0) |=> (done && div_err && rate_hz == '0));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && cfg[15] && cfg[7:0] != 8'd0) |=> busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rate_hz) && $stable(div_err)));
endmodule

bind clk_rate_calc clk_rate_calc_chk #(.RW(RW)) u_chk (.*);

// File: tb/tb_clk_rate_calc.sv
module tb_clk_rate_calc;
  localparam int IW = 40;
  localparam int L_INT  = IW + 2;
  localparam int L_FRAC = 3 * (IW + 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cfg = '0;
  logic [31:0] parent_hz = '0;
  logic        busy, done, div_err;
  logic [31:0] rate_hz;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  clk_rate_calc dut (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .parent_hz(parent_hz),
    .busy(busy), .done(done), .rate_hz(rate_hz), .div_err(div_err)
  );

  // Behavioural reference
  bit          m_busy, m_done, m_err, p_err;
  longint      m_rate, p_rate;
  int          cnt;
  string       p_tag, v_tag;

  task automatic predict(input logic [15:0] c, input logic [31:0] par,
                         output longint r, output bit e, output int lat,
                         output string tag);
    longint base, n, m, q, rr;
    int tv;
    e = 0; r = 0;
    if (!c[15]) begin lat = 0; tag = "R2"; end
    else if (c[7:0] == 0) begin lat = 0; e = 1; tag = "R3"; end
    else begin
      base = longint'(par) / longint'(c[7:0]);
      if (!c[14]) begin r = base; lat = L_INT; tag = "R4"; end
      else begin
        case (c[13:12]) 2'd0: tv = 0; 2'd1: tv = 16; 2'd2: tv = 8; default: tv = 4; endcase
        n = longint'(tv) * (1 + longint'(c[10:8]));
        if (n == 0) begin lat = L_INT; tag = "R6"; end
        else begin
          m = c[11] ? n - 1 : n + 1;
          q = base * n / m;
          rr = q % 1000;
          if (rr != 0) q = q + 1000 - rr;
          lat = L_FRAC;
          tag = "R5";
          if (rr == 0) tag = "R10";
          if (q > 64'hFFFF_FFFF) begin q = 64'hFFFF_FFFF; tag = "R7"; end
          r = q;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    longint r; bit e; int lat; string tg;
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_rate = 0; m_err = 0; cnt = 0; v_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        cnt--;
        if (cnt == 0) begin
          m_busy = 0; m_done = 1; m_rate = p_rate; m_err = p_err; v_tag = p_tag;
        end
      end else if (start) begin
        predict(cfg, parent_hz, r, e, lat, tg);
        if (lat == 0) begin
          m_done = 1; m_rate = r; m_err = e; v_tag = tg;
        end else begin
          m_busy = 1; cnt = lat; p_rate = r; p_err = e; p_tag = tg;
        end
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R8", busy, m_busy, "busy");
      check("R9", done, m_done, "done");
      check(v_tag, rate_hz, m_rate, "rate_hz");
      check(v_tag, div_err, m_err, "div_err");
    end
  end

  task automatic run_op(input logic [15:0] c, input logic [31:0] p);
    @(negedge clk);
    cfg = c; parent_hz = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", busy, 0, "busy after reset");
    check("R1", done, 0, "done after reset");
    check("R1", rate_hz, 0, "rate after reset");
    check("R1", div_err, 0, "err after reset");
    rst = 1'b0;

    run_op(16'h7FFF, 32'd123_456);                                     // R2
    run_op(16'h8000 | 16'h4F00, 32'd50_000_000);                       // R3
    run_op(16'h8000 | 16'd7, 32'd100_000_003);                         // R4
    run_op(16'h8000 | 16'd255, 32'hFFFF_FFFF);                         // R4
    run_op(16'hC000 | (16'd1 << 12) | 16'd2, 32'd625_000_000);         // R5
    run_op(16'hC000 | (16'd2 << 12) | (16'd3 << 8) | 16'h0800 | 16'd5,
           32'd1_000_000_000);                                         // R5
    run_op(16'hC000 | 16'h0800 | 16'd3, 32'd900_000_000);              // R6
    run_op(16'hC000 | 16'h0800 | (16'd3 << 12) | 16'd1, 32'hFFFF_FFFF); // R7
    run_op(16'hC000 | (16'd3 << 12) | 16'd1, 32'd1_700_000);           // R10

    // R8: start while busy is ignored
    @(negedge clk);
    cfg = 16'hC000 | (16'd1 << 12) | 16'd3; parent_hz = 32'd777_777_777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    cfg = 16'h8000 | 16'd1; parent_hz = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
    // R9: start in the done cycle is accepted
    cfg = 16'h8000 | 16'd9; parent_hz = 32'd999_999_999; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    lf = 32'h1234_5678;
    for (int i = 0; i < 16; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_op(lf[15:0] | 16'h8000, lf ^ 32'h9E37_79B9);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 200_000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule